// File: doc/BRIEF.md
# Representation-Aware Single-Step Shift and Rotate Unit

This block moves an 8-bit word by one bit position each time a start strobe is seen. It does logical shifts and arithmetic shifts, and it does rotates both outside and through the carry flag. For an arithmetic shift the caller says how the operand is encoded: sign-magnitude, one's complement or two's complement. That choice, together with the sign bit and the direction, decides which bit enters the vacated position.

The result and the updated carry are held in registers. Both update together on the clock edge that samples the strobe. When the strobe is low they keep their values. A multi-bit shift is done by issuing one strobe per position and feeding the result back in as the next operand.

Top module: `bitshift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes 0x00 and `carry_out` becomes 0.
- R2: When `start` is low at a clock edge, `result` and `carry_out` keep their values whatever the other inputs do.
- R3: With `op`=0 (logical shift), the vacated bit is 0 in both directions. `carry_out` takes the bit shifted out: bit 7 for a left shift (`dir_right`=0) and bit 0 for a right shift (`dir_right`=1).
- R4: With `op`=1 (arithmetic shift), bit 7 of `result` equals bit 7 of the operand. Only bits 6..0 move.
- R5: In an arithmetic shift of an operand whose bit 7 is 0, the vacated bit is 0 for every `repr` value.
- R6: With `repr`=0 (sign-magnitude), a negative operand gets a 0 in the vacated bit in both directions.
- R7: With `repr`=2 (two's complement), a negative operand gets a 0 in the vacated bit on a left shift and a 1 on a right shift.
- R8: With `repr`=1 (one's complement), a negative operand gets a 1 in the vacated bit in both directions.
- R9: In an arithmetic shift, `carry_out` takes the value bit that leaves the word. That is bit 6 on a left shift and bit 0 on a right shift.
- R10: With `op`=2 (rotate), on a left rotate bit 7 goes into bit 0, and on a right rotate bit 0 goes into bit 7. In both cases that same bit is copied into `carry_out`.
- R11: With `op`=3 (rotate through carry), `carry_in` enters bit 0 on a left rotate and bit 7 on a right rotate. The bit that leaves the word (bit 7 on a left rotate, bit 0 on a right rotate) becomes `carry_out`.
- R12: The `repr` value 3 behaves exactly like two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Perform one single-bit step this cycle |
| operand | input | 8 | Word to be moved |
| op | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 rotate through carry |
| repr | input | 2 | 0 sign-magnitude, 1 one's complement, 2 and 3 two's complement |
| dir_right | input | 1 | 0 left, 1 right |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Registered shifted word |
| carry_out | output | 1 | Registered updated carry flag |

## Verification
Several rules are checked on every cycle by the assertions: the reset values, holding when there is no strobe, keeping the sign bit in arithmetic shifts, zero fill in logical shifts, and the bit that moves into the word and into the carry in both rotate modes. The fill bit of an arithmetic shift depends on the encoding, the sign and the direction. It is shown only by the bench's directed scenarios, which compare whole result words and carry values that were worked out by hand for each encoding. The same holds for the arithmetic carry and for reserved encoding 3.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [1:0] {
        OP_LOGIC = 2'd0,
        OP_ARITH = 2'd1,
        OP_ROT   = 2'd2,
        OP_ROTC  = 2'd3
    } shift_op_e;

    typedef enum logic [1:0] {
        REP_SIGNMAG = 2'd0,
        REP_ONES    = 2'd1,
        REP_TWOS    = 2'd2,
        REP_TWOS_X  = 2'd3
    } num_repr_e;

    typedef struct packed {
        shift_op_e op;
        num_repr_e repr;
        logic      right;
        logic      cin;
    } step_ctrl_t;

    // Bit entering the vacated magnitude slot of an arithmetic shift.
    function automatic logic arith_fill(input num_repr_e repr, input logic neg, input logic right);
        logic f;
        if (!neg) begin
            f = 1'b0;
        end else begin
            case (repr)
                REP_SIGNMAG: f = 1'b0;
                REP_ONES:    f = 1'b1;
                default:     f = right;
            endcase
        end
        return f;
    endfunction

endpackage

// File: rtl/shift_fill.sv
module shift_fill
    import shift_pkg::*;
(
    input  step_ctrl_t ctrl,
    input  logic       sign_bit,
    output logic       fill_bit
);
    always_comb begin
        case (ctrl.op)
            OP_LOGIC: fill_bit = 1'b0;
            OP_ARITH: fill_bit = arith_fill(ctrl.repr, sign_bit, ctrl.right);
            OP_ROTC:  fill_bit = ctrl.cin;
            default:  fill_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  step_ctrl_t   ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         cout
);
    localparam int MSB = W - 1;

    logic fill;

    shift_fill u_fill (
        .ctrl     (ctrl),
        .sign_bit (din[MSB]),
        .fill_bit (fill)
    );

    always_comb begin
        dout = din;
        cout = 1'b0;
        case (ctrl.op)
            OP_ARITH: begin
                if (ctrl.right) begin
                    dout = {din[MSB], fill, din[MSB-1:1]};
                    cout = din[0];
                end else begin
                    dout = {din[MSB], din[MSB-2:0], fill};
                    cout = din[MSB-1];
                end
            end
            OP_ROT: begin
                if (ctrl.right) begin
                    dout = {din[0], din[MSB:1]};
                    cout = din[0];
                end else begin
                    dout = {din[MSB-1:0], din[MSB]};
                    cout = din[MSB];
                end
            end
            default: begin
                if (ctrl.right) begin
                    dout = {fill, din[MSB:1]};
                    cout = din[0];
                end else begin
                    dout = {din[MSB-1:0], fill};
                    cout = din[MSB];
                end
            end
        endcase
    end
endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit
    import shift_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WORD_W-1:0]   operand,
    input  logic [1:0]          op,
    input  logic [1:0]          repr,
    input  logic                dir_right,
    input  logic                carry_in,
    output logic [WORD_W-1:0]   result,
    output logic                carry_out
);
    localparam int MSB = WORD_W - 1;

    step_ctrl_t          ctrl;
    logic [WORD_W-1:0]   next_word;
    logic                next_carry;

    assign ctrl = '{op: shift_op_e'(op), repr: num_repr_e'(repr), right: dir_right, cin: carry_in};

    shift_core #(.W(WORD_W)) u_core (
        .ctrl (ctrl),
        .din  (operand),
        .dout (next_word),
        .cout (next_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            carry_out <= 1'b0;
        end else if (start) begin
            result    <= next_word;
            carry_out <= next_carry;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (result == '0 && carry_out == 1'b0));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(carry_out)));

    a_r3_logic_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd0) |=>
            ($past(dir_right) ? (result[MSB] == 1'b0) : (result[0] == 1'b0)));

    a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd1) |=> (result[MSB] == $past(operand[MSB])));

    a_r10_rotate_loop: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd2) |=>
            ($past(dir_right)
                ? (result[MSB] == $past(operand[0]) && carry_out == $past(operand[0]))
                : (result[0] == $past(operand[MSB]) && carry_out == $past(operand[MSB]))));

    a_r11_carry_loop: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd3) |=>
            ($past(dir_right)
                ? (result[MSB] == $past(carry_in) && carry_out == $past(operand[0]))
                : (result[0] == $past(carry_in) && carry_out == $past(operand[MSB]))));
endmodule

// File: tb/bitshift_unit_test.sv
`timescale 1ns/100ps
module bitshift_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] operand = '0;
    logic [1:0] op = '0;
    logic [1:0] repr = '0;
    logic       dir_right = 1'b0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       carry_out;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bitshift_unit uut (
        .clk(clk), .rst(rst), .start(start), .operand(operand), .op(op),
        .repr(repr), .dir_right(dir_right), .carry_in(carry_in),
        .result(result), .carry_out(carry_out)
    );

    task automatic check(input string tag, input logic [7:0] got_w, input logic [7:0] exp_w,
                         input logic got_c, input logic exp_c);
        checks++;
        if (got_w !== exp_w || got_c !== exp_c) begin
            fails++;
            $display("FAIL %s: result=%02h carry=%0b expected result=%02h carry=%0b",
                     tag, got_w, got_c, exp_w, exp_c);
        end
    endtask

    // One strobe; sample at the following falling edge, after the register updated.
    task automatic step(input logic [1:0] o, input logic [1:0] r, input logic d,
                        input logic ci, input logic [7:0] v);
        @(negedge clk);
        op = o; repr = r; dir_right = d; carry_in = ci; operand = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset", result, 8'h00, carry_out, 1'b0);
    endtask

    task automatic t_logical;
        step(2'd0, 2'd0, 1'b0, 1'b0, 8'hB5); check("R3 logical left",  result, 8'h6A, carry_out, 1'b1);
        step(2'd0, 2'd2, 1'b1, 1'b0, 8'hB5); check("R3 logical right", result, 8'h5A, carry_out, 1'b1);
    endtask

    task automatic t_positive;
        for (int r = 0; r < 3; r++) begin
            step(2'd1, 2'(r), 1'b0, 1'b1, 8'h35); check("R5 positive left",  result, 8'h6A, carry_out, 1'b0);
            step(2'd1, 2'(r), 1'b1, 1'b0, 8'h35); check("R5 positive right", result, 8'h1A, carry_out, 1'b1);
        end
    endtask

    task automatic t_signmag;
        step(2'd1, 2'd0, 1'b0, 1'b0, 8'hC5); check("R6 signmag left",  result, 8'h8A, carry_out, 1'b1);
        step(2'd1, 2'd0, 1'b1, 1'b0, 8'hC5); check("R6 signmag right R4", result, 8'hA2, carry_out, 1'b1);
    endtask

    task automatic t_twos;
        step(2'd1, 2'd2, 1'b0, 1'b0, 8'hC5); check("R7 twos left",  result, 8'h8A, carry_out, 1'b1);
        step(2'd1, 2'd2, 1'b1, 1'b0, 8'hC5); check("R7 twos right", result, 8'hE2, carry_out, 1'b1);
    endtask

    task automatic t_ones;
        step(2'd1, 2'd1, 1'b0, 1'b0, 8'hC5); check("R8 ones left",  result, 8'h8B, carry_out, 1'b1);
        step(2'd1, 2'd1, 1'b1, 1'b0, 8'hC5); check("R8 ones right", result, 8'hE2, carry_out, 1'b1);
    endtask

    task automatic t_arith_carry;
        step(2'd1, 2'd2, 1'b0, 1'b1, 8'h81); check("R9 carry left",  result, 8'h82, carry_out, 1'b0);
        step(2'd1, 2'd2, 1'b1, 1'b0, 8'h81); check("R9 carry right", result, 8'hC0, carry_out, 1'b1);
    endtask

    task automatic t_rotate;
        step(2'd2, 2'd0, 1'b0, 1'b0, 8'h96); check("R10 rotate left",  result, 8'h2D, carry_out, 1'b1);
        step(2'd2, 2'd0, 1'b1, 1'b1, 8'h96); check("R10 rotate right", result, 8'h4B, carry_out, 1'b0);
    endtask

    task automatic t_rotc;
        step(2'd3, 2'd0, 1'b0, 1'b0, 8'h96); check("R11 through-carry left",  result, 8'h2C, carry_out, 1'b1);
        step(2'd3, 2'd0, 1'b1, 1'b1, 8'h96); check("R11 through-carry right", result, 8'hCB, carry_out, 1'b0);
    endtask

    task automatic t_repr3;
        step(2'd1, 2'd3, 1'b0, 1'b0, 8'hC5); check("R12 code3 left",  result, 8'h8A, carry_out, 1'b1);
        step(2'd1, 2'd3, 1'b1, 1'b0, 8'hC5); check("R12 code3 right", result, 8'hE2, carry_out, 1'b1);
    endtask

    task automatic t_hold;
        step(2'd2, 2'd0, 1'b1, 1'b0, 8'h01);
        check("R2 before idle", result, 8'h80, carry_out, 1'b1);
        @(negedge clk);
        op = 2'd0; operand = 8'h7E; dir_right = 1'b0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 idle hold", result, 8'h80, carry_out, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", result, 8'h00, carry_out, 1'b0);
        rst = 1'b0;
        t_reset();
        t_logical();
        t_positive();
        t_signmag();
        t_twos();
        t_ones();
        t_arith_carry();
        t_rotate();
        t_rotc();
        t_repr3();
        t_hold();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #50000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule